// File: doc/BRIEF.md
# Dual-Channel DAC Command Decoder

This block sits behind a serial receiver that has already assembled and committed a 16-bit frame. It splits each frame into a 4-bit command and a 12-bit data field. It then maintains a register file for two converter channels, A and B. Each channel keeps an input (staging) register and an output register that drives the converter. The command selects one of four kinds of work: load a channel with or without an output update, move staged values to the outputs, clear everything to zero scale or midscale, or change the mode configuration. A readback request carrying the selected channel is also a command.

A separate active-low update pin, `ldac_n`, gives two update styles. When the pin falls, both staged values are copied to the outputs together. While the pin is held low, every load also reaches the output in the same cycle in which its frame commits. The outputs of the block are the two output registers, the configuration fields and a one-cycle readback request with its channel number.

Top module: `dac_cmd_decoder`

## Requirements
- R1: After reset both channels' input and output registers are 0, `cfg_chain_en` is 1, `cfg_sdo`, `cfg_hclr_sel`, `cfg_edge_rise` and `rb_req` are 0.
- R2: A frame is taken when `frame_valid` is high at a rising clock edge. The command is `frame_data[15:12]` and the data is `frame_data[11:0]`, and the effect shows at the outputs one cycle later. Commands 0x0, 0xE and 0xF, and any cycle with `frame_valid` low, leave every register unchanged.
- R3: Command 0x1 writes the data into channel A's input and output registers. Command 0x4 does the same for channel B.
- R4: Command 0x3 (channel A) or 0x6 (channel B) writes only that channel's input register, and the output keeps its value while `ldac_n` is high.
- R5: Command 0x8 writes the data into both input registers. Command 0x7 copies each input register to its output register.
- R6: When `ldac_n` is sampled high at one clock edge and low at the next, both input registers are copied to the outputs at that next edge. Any frame committed at the same edge takes precedence for the registers it writes.
- R7: If `ldac_n` is low when a frame with command 0x3, 0x6 or 0x8 commits, the loaded output registers take the data in the same cycle as the input registers.
- R8: Command 0xB sets all four data registers to 0. Command 0xC sets all four to midscale, 0x800, which is 1 shifted left by DATA_W-1.
- R9: Command 0xD loads the configuration from the data field: `cfg_sdo` from bits 11:10, `cfg_chain_en` from bit 9, `cfg_hclr_sel` from bit 8 and `cfg_edge_rise` from bit 7. Bits 6:0 are ignored.
- R10: Command 0x9 clears only `cfg_chain_en`. Command 0xA sets only `cfg_edge_rise`.
- R11: Command 0x2 or 0x5 raises `rb_req` for exactly the following cycle, with `rb_chan` 0 for A or 1 for B. `rb_req` is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | Committed frame present this cycle |
| frame_data | input | 16 | Command in the top 4 bits, data below |
| ldac_n | input | 1 | Active-low output update pin |
| out_a | output | 12 | Channel A output register |
| out_b | output | 12 | Channel B output register |
| cfg_sdo | output | 2 | Serial-out control field |
| cfg_chain_en | output | 1 | Daisy-chain enable |
| cfg_hclr_sel | output | 1 | Hardware-clear target select |
| cfg_edge_rise | output | 1 | Shift on rising clock edge |
| rb_req | output | 1 | Readback request pulse |
| rb_chan | output | 1 | Channel of the readback request |

## Verification
The bench builds the block at its default DATA_W of 12. This places midscale at 0x800 and the configuration fields in data bits 11 to 7, so the directed frames can hit exact bit positions, including the ignored low seven bits. Random frames draw the full 4-bit command space and 12-bit data, with `ldac_n` toggled now and then. This brings the reserved and no-op codes within reach, along with pin falls that coincide with loads and clears.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  localparam int CMD_W = 4;
  localparam int NCH   = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP       = 4'h0,
    CMD_LDUP_A    = 4'h1,
    CMD_RB_A      = 4'h2,
    CMD_LD_A      = 4'h3,
    CMD_LDUP_B    = 4'h4,
    CMD_RB_B      = 4'h5,
    CMD_LD_B      = 4'h6,
    CMD_UPD_ALL   = 4'h7,
    CMD_LD_ALL    = 4'h8,
    CMD_CHAIN_OFF = 4'h9,
    CMD_EDGE_RISE = 4'hA,
    CMD_CLR_ZERO  = 4'hB,
    CMD_CLR_MID   = 4'hC,
    CMD_CFG_WR    = 4'hD,
    CMD_RSVD      = 4'hE,
    CMD_NOP_ALT   = 4'hF
  } cmd_e;

  typedef struct packed {
    logic [NCH-1:0] load;      // input register only
    logic [NCH-1:0] load_upd;  // input and output register
    logic           upd_all;
    logic           clr_zero;
    logic           clr_mid;
    logic [NCH-1:0] rb;
    logic           cfg_wr;
    logic           chain_off;
    logic           edge_set;
  } act_t;

  typedef struct packed {
    logic [1:0] sdo;
    logic       chain_en;
    logic       hclr_sel;
    logic       edge_rise;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{sdo: 2'b00, chain_en: 1'b1, hclr_sel: 1'b0, edge_rise: 1'b0};

  // Midscale code for a converter of width dw: only the top bit set.
  function automatic logic [31:0] midscale_code(int dw);
    return 32'd1 << (dw - 1);
  endfunction

  // Configuration fields taken from the top five bits of a dw-bit data word.
  function automatic cfg_t cfg_from_word(logic [31:0] word, int dw);
    cfg_t c;
    c.sdo       = word[dw-1 -: 2];
    c.chain_en  = word[dw-3];
    c.hclr_sel  = word[dw-4];
    c.edge_rise = word[dw-5];
    return c;
  endfunction

endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [CMD_W-1:0] cmd,
  output act_t             act
);

  always_comb begin
    act = '0;
    if (valid) begin
      case (cmd_e'(cmd))
        CMD_LDUP_A:    act.load_upd[0] = 1'b1;
        CMD_RB_A:      act.rb[0]       = 1'b1;
        CMD_LD_A:      act.load[0]     = 1'b1;
        CMD_LDUP_B:    act.load_upd[1] = 1'b1;
        CMD_RB_B:      act.rb[1]       = 1'b1;
        CMD_LD_B:      act.load[1]     = 1'b1;
        CMD_UPD_ALL:   act.upd_all     = 1'b1;
        CMD_LD_ALL:    act.load        = '1;
        CMD_CHAIN_OFF: act.chain_off   = 1'b1;
        CMD_EDGE_RISE: act.edge_set    = 1'b1;
        CMD_CLR_ZERO:  act.clr_zero    = 1'b1;
        CMD_CLR_MID:   act.clr_mid     = 1'b1;
        CMD_CFG_WR:    act.cfg_wr      = 1'b1;
        default:       act             = '0;
      endcase
    end
  end

  // R2: no frame, no action
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (act == '0));

  // R11: at most one readback channel per frame
  p_rb_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act.rb));

endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_upd,
  input  logic              copy,
  input  logic              clr_zero,
  input  logic              clr_mid,
  input  logic              auto_upd,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] in_q,
  output logic [DATA_W-1:0] out_q
);

  localparam logic [DATA_W-1:0] MID = DATA_W'(midscale_code(DATA_W));

  logic [DATA_W-1:0] in_n, out_n;
  logic              any_act;

  assign any_act = load | load_upd | copy | clr_zero | clr_mid;

  always_comb begin
    in_n  = in_q;
    out_n = out_q;
    if (copy) out_n = in_q;
    if (load | load_upd) in_n = din;
    if (load_upd | (load & auto_upd)) out_n = din;
    if (clr_zero) begin
      in_n  = '0;
      out_n = '0;
    end
    if (clr_mid) begin
      in_n  = MID;
      out_n = MID;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      in_q  <= in_n;
      out_q <= out_n;
    end
  end

  // R2: nothing requested, both registers hold
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_act |=> ($stable(in_q) && $stable(out_q)));

  // R3: load-and-update reaches both registers
  p_ldup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load_upd |=> (in_q == $past(din)) && (out_q == $past(din)));

  // R4: staged load without pin keeps output
  p_ldonly_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !auto_upd && !copy) |=> (out_q == $past(out_q)) && (in_q == $past(din)));

  // R6: plain copy moves staged value to output
  p_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (copy && !load && !load_upd && !clr_zero && !clr_mid) |=> (out_q == $past(in_q)));

  // R7: automatic update while the pin is low
  p_auto_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load && auto_upd) |=> (out_q == $past(din)));

  // R8: clears hit both registers
  p_clr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_zero |=> (in_q == '0) && (out_q == '0));
  p_clr_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_mid |=> (in_q == MID) && (out_q == MID));

endmodule

// File: rtl/dac_cfg_regs.sv
module dac_cfg_regs
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              chain_off,
  input  logic              edge_set,
  input  logic [DATA_W-1:0] din,
  output cfg_t              cfg_q
);

  cfg_t        cfg_n;
  logic [31:0] din_wide;

  assign din_wide = {{(32-DATA_W){1'b0}}, din};

  always_comb begin
    cfg_n = cfg_q;
    if (cfg_wr)    cfg_n = cfg_from_word(din_wide, DATA_W);
    if (chain_off) cfg_n.chain_en = 1'b0;
    if (edge_set)  cfg_n.edge_rise = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_n;
  end

  // R9: enable field comes from data bit DATA_W-3
  p_cfg_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_q.chain_en == $past(din[DATA_W-3])));

  // R10: chain disable touches only its own bit
  p_chain_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    chain_off |=> (!cfg_q.chain_en && cfg_q.sdo == $past(cfg_q.sdo)
                   && cfg_q.edge_rise == $past(cfg_q.edge_rise)));

  // R10: edge select sets only its own bit
  p_edge_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    edge_set |=> (cfg_q.edge_rise && cfg_q.chain_en == $past(cfg_q.chain_en)));

  // R2: no configuration command, configuration stable
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr || chain_off || edge_set) |=> $stable(cfg_q));

endmodule

// File: rtl/dac_cmd_decoder.sv
module dac_cmd_decoder
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12,
  localparam int FRAME_W = CMD_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_valid,
  input  logic [FRAME_W-1:0] frame_data,
  input  logic               ldac_n,
  output logic [DATA_W-1:0]  out_a,
  output logic [DATA_W-1:0]  out_b,
  output logic [1:0]         cfg_sdo,
  output logic               cfg_chain_en,
  output logic               cfg_hclr_sel,
  output logic               cfg_edge_rise,
  output logic               rb_req,
  output logic               rb_chan
);

  logic [CMD_W-1:0]  frame_cmd;
  logic [DATA_W-1:0] frame_dat;
  act_t              act;
  cfg_t              cfg_q;

  logic              ldac_q;
  logic              ldac_fall;
  logic              auto_upd;
  logic              copy_all;

  logic [DATA_W-1:0] in_q  [NCH];
  logic [DATA_W-1:0] out_q [NCH];

  logic              rb_req_q;
  logic              rb_chan_q;

  assign frame_cmd = frame_data[FRAME_W-1 -: CMD_W];
  assign frame_dat = frame_data[DATA_W-1:0];

  // Pin edge detect: high at last edge, low now.
  always_ff @(posedge clk) begin
    if (!rst_n) ldac_q <= 1'b1;
    else        ldac_q <= ldac_n;
  end

  assign ldac_fall = ldac_q & ~ldac_n;
  assign auto_upd  = ~ldac_n;

  dac_cmd_decode u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .valid (frame_valid),
    .cmd   (frame_cmd),
    .act   (act)
  );

  assign copy_all = act.upd_all | ldac_fall;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dac_chan_regs #(.DATA_W(DATA_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (act.load[ch]),
      .load_upd (act.load_upd[ch]),
      .copy     (copy_all),
      .clr_zero (act.clr_zero),
      .clr_mid  (act.clr_mid),
      .auto_upd (auto_upd),
      .din      (frame_dat),
      .in_q     (in_q[ch]),
      .out_q    (out_q[ch])
    );
  end

  dac_cfg_regs #(.DATA_W(DATA_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (act.cfg_wr),
    .chain_off (act.chain_off),
    .edge_set  (act.edge_set),
    .din       (frame_dat),
    .cfg_q     (cfg_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_req_q  <= 1'b0;
      rb_chan_q <= 1'b0;
    end else begin
      rb_req_q <= |act.rb;
      if (|act.rb) rb_chan_q <= act.rb[1];
    end
  end

  assign out_a         = out_q[0];
  assign out_b         = out_q[1];
  assign cfg_sdo       = cfg_q.sdo;
  assign cfg_chain_en  = cfg_q.chain_en;
  assign cfg_hclr_sel  = cfg_q.hclr_sel;
  assign cfg_edge_rise = cfg_q.edge_rise;
  assign rb_req        = rb_req_q;
  assign rb_chan       = rb_chan_q;

  // R6: pin fall with no frame copies both staged values
  p_ldac_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_fall && !frame_valid) |=> (out_a == $past(in_q[0])) && (out_b == $past(in_q[1])));

  // R11: a request only follows a committed frame
  p_rb_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req |-> $past(frame_valid));

  // R11: channel B request reports channel 1
  p_rb_chan_b_r11: assert property (@(posedge clk) disable iff (!rst_n)
    act.rb[1] |=> (rb_req && rb_chan));

  // R11: channel A request reports channel 0
  p_rb_chan_a_r11: assert property (@(posedge clk) disable iff (!rst_n)
    act.rb[0] |=> (rb_req && !rb_chan));

endmodule

// File: tb/tb_dac_cmd_decoder.sv
module tb_dac_cmd_decoder;

  localparam int W = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_valid = 1'b0;
  logic [15:0]   frame_data = '0;
  logic          ldac_n = 1'b1;
  logic [W-1:0]  out_a, out_b;
  logic [1:0]    cfg_sdo;
  logic          cfg_chain_en, cfg_hclr_sel, cfg_edge_rise, rb_req, rb_chan;

  dac_cmd_decoder #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_data(frame_data),
    .ldac_n(ldac_n), .out_a(out_a), .out_b(out_b), .cfg_sdo(cfg_sdo),
    .cfg_chain_en(cfg_chain_en), .cfg_hclr_sel(cfg_hclr_sel),
    .cfg_edge_rise(cfg_edge_rise), .rb_req(rb_req), .rb_chan(rb_chan)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference state
  logic [W-1:0] m_in [2];
  logic [W-1:0] m_out[2];
  logic [1:0]   m_sdo;
  logic         m_chain, m_hclr, m_edge, m_rb, m_rbch, m_ldac_prev;

  function automatic logic [W-1:0] exp_mid();
    logic [W-1:0] v;
    v = '0;
    v[W-1] = 1'b1;
    return v;
  endfunction

  function automatic string tag_of(bit v, logic [3:0] c, bit fall);
    if (!v) return fall ? "R6" : "R2";
    case (c)
      4'h1, 4'h4: return "R3";
      4'h3, 4'h6: return "R4/R7";
      4'h7, 4'h8: return "R5";
      4'hB, 4'hC: return "R8";
      4'hD:       return "R9";
      4'h9, 4'hA: return "R10";
      4'h2, 4'h5: return "R11";
      default:    return "R2";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "out_a", 32'(out_a), 32'(m_out[0]));
    chk(tag, "out_b", 32'(out_b), 32'(m_out[1]));
    chk(tag, "cfg", {27'd0, cfg_sdo, cfg_chain_en, cfg_hclr_sel, cfg_edge_rise},
        {27'd0, m_sdo, m_chain, m_hclr, m_edge});
    chk(tag, "rb_req", 32'(rb_req), 32'(m_rb));
    if (m_rb) chk(tag, "rb_chan", 32'(rb_chan), 32'(m_rbch));
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_in[i]  = '0;
      m_out[i] = '0;
    end
    m_sdo = 2'b00; m_chain = 1'b1; m_hclr = 1'b0; m_edge = 1'b0;
    m_rb = 1'b0; m_rbch = 1'b0; m_ldac_prev = 1'b1;
  endtask

  task automatic step(bit v, logic [3:0] c, logic [W-1:0] d, bit l, string tag);
    bit fall;
    logic [W-1:0] n_in [2];
    logic [W-1:0] n_out[2];
    @(negedge clk);
    frame_valid = v;
    frame_data  = {c, d};
    ldac_n      = l;
    fall = m_ldac_prev && !l;
    for (int i = 0; i < 2; i++) begin
      n_in[i]  = m_in[i];
      n_out[i] = fall ? m_in[i] : m_out[i];
    end
    m_rb = 1'b0;
    if (v) begin
      case (c)
        4'h1: begin n_in[0] = d; n_out[0] = d; end
        4'h4: begin n_in[1] = d; n_out[1] = d; end
        4'h3: begin n_in[0] = d; if (!l) n_out[0] = d; end
        4'h6: begin n_in[1] = d; if (!l) n_out[1] = d; end
        4'h7: begin n_out[0] = m_in[0]; n_out[1] = m_in[1]; end
        4'h8: for (int i = 0; i < 2; i++) begin
                n_in[i] = d;
                if (!l) n_out[i] = d;
              end
        4'hB: for (int i = 0; i < 2; i++) begin n_in[i] = '0; n_out[i] = '0; end
        4'hC: for (int i = 0; i < 2; i++) begin n_in[i] = exp_mid(); n_out[i] = exp_mid(); end
        4'hD: begin m_sdo = d[11:10]; m_chain = d[9]; m_hclr = d[8]; m_edge = d[7]; end
        4'h9: m_chain = 1'b0;
        4'hA: m_edge = 1'b1;
        4'h2: begin m_rb = 1'b1; m_rbch = 1'b0; end
        4'h5: begin m_rb = 1'b1; m_rbch = 1'b1; end
        default: ;
      endcase
    end
    for (int i = 0; i < 2; i++) begin
      m_in[i]  = n_in[i];
      m_out[i] = n_out[i];
    end
    m_ldac_prev = l;
    @(posedge clk);
    #1;
    check_all(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_0D4C);
    model_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_all("R1");

    // Directed cases
    step(1, 4'h1, 12'h123, 1, "R3");
    step(1, 4'h4, 12'hABC, 1, "R3");
    step(1, 4'h3, 12'h456, 1, "R4");
    step(1, 4'h6, 12'h789, 1, "R4");
    step(1, 4'h0, 12'hFFF, 1, "R2");
    step(1, 4'hE, 12'hFFF, 1, "R2");
    step(1, 4'hF, 12'hFFF, 1, "R2");
    step(0, 4'h1, 12'h777, 1, "R2");
    step(1, 4'h7, 12'h000, 1, "R5");
    step(1, 4'h8, 12'h321, 1, "R5");
    step(0, 4'h0, 12'h000, 0, "R6");
    step(0, 4'h0, 12'h000, 0, "R6");
    step(1, 4'h6, 12'h0AA, 0, "R7");
    step(1, 4'h8, 12'h055, 0, "R7");
    step(1, 4'h3, 12'hF0F, 0, "R7");
    step(0, 4'h0, 12'h000, 1, "R6");
    step(1, 4'h3, 12'h111, 1, "R4");
    step(1, 4'h1, 12'h222, 0, "R6");
    step(1, 4'hB, 12'h5A5, 1, "R8");
    step(1, 4'hC, 12'h5A5, 1, "R8");
    step(1, 4'hD, 12'b10_1_1_1_1111111, 1, "R9");
    step(1, 4'hD, 12'h07F, 1, "R9");
    step(1, 4'hD, 12'b01_1_0_1_0000000, 1, "R9");
    step(1, 4'h9, 12'hFFF, 1, "R10");
    step(1, 4'hA, 12'h000, 1, "R10");
    step(1, 4'h2, 12'h000, 1, "R11");
    step(0, 4'h0, 12'h000, 1, "R11");
    step(1, 4'h5, 12'h000, 1, "R11");
    step(1, 4'h1, 12'h333, 1, "R11");

    // Constrained random frames
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r;
      bit v, l;
      logic [3:0] c;
      r = $urandom;
      v = (r[3:0] < 4'd11);
      c = r[7:4];
      l = (r[11:8] == 4'd0) ? ~ldac_n : ldac_n;
      step(v, c, r[27:16], l, tag_of(v, c, m_ldac_prev && !l));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule